// File: doc/BRIEF.md
# Clock Control Register Bank

This block is the software-visible state store of a clock and reset controller. It holds 28 words of 32 bits: clock-gate enables, source selects, divider settings, peripheral reset masks, watchdog reset routing, software reset configuration, four PLL control words and a bus-frequency hint. A simple word-wide bus with separate read and write strobes reaches these words. The block does not generate clocks and does not drive resets. Its stored words are the configuration that downstream clock logic would consume.

Each word follows one of four access rules. Plain words take the full written value. PLL control words maintain their own lock and loss-of-lock status bits. A trigger word is write-only and never keeps data. Two time-reference words reflect external counter inputs and are read-only. A cold reset (asynchronous, active low) loads fixed start-up values. Any illegal access is reported on an error flag, in the same cycle as the returned read data.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, the words read by byte offset hold these values: 0x00, 0x28, 0x30 and 0x38..0x40 read 0xFFFFFFFF; 0x04 reads 0x004AAAAA; 0x08 reads 0x5413F855; 0x2C reads 0xAA4F8F9F; 0x20 reads 0x00001000; 0x24 reads 0x80000000; 0x34 reads 0x03000000; 0x44 reads 0x3; 0x5C reads 0x04000003; 0x64 reads 0xC8; the PLL words read 0x0C=0x80222101, 0x10=0x80202101, 0x54=0x80C02105 and 0x60=0x81228606; every other word reads 0.
- R2: A write to a plain word (any offset 0x00..0x64 other than 0x0C, 0x10, 0x14, 0x54, 0x60) stores the full 32-bit word. A read returns data and the error flag in the cycle after the read strobe.
- R3: A write to a PLL word (0x0C, 0x10, 0x54, 0x60) with bit 12 set stores the written word with bit 31 forced to 0 and bit 30 forced to 1.
- R4: A PLL write with bit 12 clear stores the written word with bit 31 forced to 1. If the written bit 30 is 1, bit 30 becomes 0.
- R5: A PLL write with bit 12 clear and bit 30 clear leaves the stored bit 30 unchanged.
- R6: Offset 0x14 is write-only. A read returns 0 and raises the error flag. A write is accepted with no error and leaves nothing to read back.
- R7: Offset 0x68 returns the seconds counter input and 0x6C returns the tick counter input. A write to either raises the error flag and changes no stored word.
- R8: An aligned offset at 0x70 or above reads 0 and raises the error flag. A write there raises the error flag and changes no word.
- R9: An offset whose two low bits are nonzero reads 0 and raises the error flag. A write there raises the error flag and changes no word.
- R10: When a read and a write hit the same word in one cycle, the read returns the content from before the write, and the write still takes effect.
- R11: In a cycle after one with no strobe, the error flag is 0 and read data is 0. After a legal access, the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (12) | Byte address of the access |
| wdata_i | input | 32 | Write data |
| sec_cnt_i | input | 32 | External seconds counter value |
| tick_cnt_i | input | 32 | External tick counter value |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Registered error flag for the previous access |

## Verification
A read and a write can fall in the same cycle, and they can hit the same PLL word. In that case the read must return the stored word from before the write, while the lock-bit update on the write still lands. The bench provokes this with directed cycles that raise both strobes on one PLL word and on one plain word. It then reads the word again and compares both results with a bench model that applies the write only after the read has sampled. Random traffic also raises both strobes together on mixed offsets, and the model judges those cycles in the same way.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int WORD_W    = 32;
   localparam int NUM_WORDS = 28;
   localparam int IDX_W     = $clog2(NUM_WORDS);
   localparam int LOCK_BIT  = 31;
   localparam int LOSS_BIT  = 30;
   localparam int PDN_BIT   = 12;

   localparam int IDX_GATE0   = 0;
   localparam int IDX_SRCSEL  = 1;
   localparam int IDX_DIV0    = 2;
   localparam int IDX_PLL_A   = 3;
   localparam int IDX_PLL_B   = 4;
   localparam int IDX_SWTRIG  = 5;
   localparam int IDX_IPRST0  = 8;
   localparam int IDX_IPRST1  = 9;
   localparam int IDX_GATE1   = 10;
   localparam int IDX_DIV1    = 11;
   localparam int IDX_GATE2   = 12;
   localparam int IDX_IPRST2  = 13;
   localparam int IDX_WDRST0  = 14;
   localparam int IDX_WDRST2  = 16;
   localparam int IDX_SWCFG0  = 17;
   localparam int IDX_PLL_C   = 21;
   localparam int IDX_CORERST = 23;
   localparam int IDX_PLL_G   = 24;
   localparam int IDX_BUSFREQ = 25;
   localparam int IDX_SECONDS = 26;
   localparam int IDX_TICKS   = 27;

   typedef enum logic [1:0] {
      KIND_PLAIN,
      KIND_PLL,
      KIND_WO,
      KIND_EXT
   } word_kind_e;

   function automatic word_kind_e kind_of(int idx);
      if (idx == IDX_PLL_A || idx == IDX_PLL_B || idx == IDX_PLL_C || idx == IDX_PLL_G)
         return KIND_PLL;
      if (idx == IDX_SWTRIG)
         return KIND_WO;
      if (idx == IDX_SECONDS || idx == IDX_TICKS)
         return KIND_EXT;
      return KIND_PLAIN;
   endfunction

   function automatic logic [WORD_W-1:0] cold_value(int idx);
      logic [WORD_W-1:0] v;
      v = '0;
      if (idx == IDX_GATE0 || idx == IDX_GATE1 || idx == IDX_GATE2 ||
          (idx >= IDX_WDRST0 && idx <= IDX_WDRST2))
         v = 32'hFFFF_FFFF;
      case (idx)
         IDX_SRCSEL:  v = 32'h004A_AAAA;
         IDX_DIV0:    v = 32'h5413_F855;
         IDX_DIV1:    v = 32'hAA4F_8F9F;
         IDX_IPRST0:  v = 32'h0000_1000;
         IDX_IPRST1:  v = 32'h8000_0000;
         IDX_IPRST2:  v = 32'h0300_0000;
         IDX_SWCFG0:  v = 32'h0000_0003;
         IDX_CORERST: v = 32'h0400_0003;
         IDX_BUSFREQ: v = 32'h0000_00C8;
         IDX_PLL_A:   v = 32'h0022_2101;
         IDX_PLL_B:   v = 32'h0020_2101;
         IDX_PLL_C:   v = 32'h00C0_2105;
         IDX_PLL_G:   v = 32'h0122_8606;
         default: ;
      endcase
      if (kind_of(idx) == KIND_PLL)
         v[LOCK_BIT] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/clkctl_addr_dec.sv
module clkctl_addr_dec
   import clkctl_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic              hit_o,
   output logic              rd_ok_o,
   output logic              wr_ok_o
);
   localparam int WIDX_W = ADDR_W - 2;

   generate
      if (WIDX_W < IDX_W) begin : g_bad_width
         $error("clkctl_addr_dec: ADDR_W too small for the word count");
      end
   endgenerate

   logic [WIDX_W-1:0] word_idx;
   logic              aligned;
   logic              in_range;
   word_kind_e        kind;

   assign word_idx = addr_i[ADDR_W-1:2];
   assign aligned  = (addr_i[1:0] == 2'b00);
   assign in_range = (word_idx < WIDX_W'(NUM_WORDS));
   assign idx_o    = word_idx[IDX_W-1:0];
   assign hit_o    = aligned && in_range;
   assign kind     = kind_of(int'(idx_o));
   assign rd_ok_o  = hit_o && (kind != KIND_WO);
   assign wr_ok_o  = hit_o && (kind != KIND_EXT);
endmodule

// File: rtl/clkctl_word_reg.sv
module clkctl_word_reg
   import clkctl_pkg::*;
#(
   parameter word_kind_e        KIND      = KIND_PLAIN,
   parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] q_o
);
   logic [WORD_W-1:0] q;
   logic [WORD_W-1:0] nxt;

   generate
      if (KIND == KIND_PLL) begin : g_pll
         always_comb begin
            nxt = wdata_i;
            if (wdata_i[PDN_BIT]) begin
               nxt[LOCK_BIT] = 1'b0;
               nxt[LOSS_BIT] = 1'b1;
            end else begin
               nxt[LOCK_BIT] = 1'b1;
               nxt[LOSS_BIT] = wdata_i[LOSS_BIT] ? 1'b0 : q[LOSS_BIT];
            end
         end

         // R3
         pdn_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && wdata_i[PDN_BIT]) |=> (!q_o[LOCK_BIT] && q_o[LOSS_BIT]));
         // R4
         run_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && !wdata_i[PDN_BIT]) |=> (q_o[LOCK_BIT] &&
               (!$past(wdata_i[LOSS_BIT]) || !q_o[LOSS_BIT])));
         // R5
         loss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && !wdata_i[PDN_BIT] && !wdata_i[LOSS_BIT]) |=>
               (q_o[LOSS_BIT] == $past(q_o[LOSS_BIT])));
      end else if (KIND == KIND_WO) begin : g_wo
         assign nxt = wdata_i & '0;
      end else begin : g_plain
         assign nxt = wdata_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         q <= RESET_VAL;
      else if (wr_i)
         q <= nxt;
   end

   assign q_o = q;
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
   import clkctl_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   input  logic [31:0]       sec_cnt_i,
   input  logic [31:0]       tick_cnt_i,
   output logic [31:0]       rdata_o,
   output logic              err_o
);
   localparam int SLOTS = 2 ** IDX_W;

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("clkctl_regbank: port width assumes 32-bit words");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              hit;
   logic              rd_ok;
   logic              wr_ok;
   logic [WORD_W-1:0] words [SLOTS];

   clkctl_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
      .addr_i  (addr_i),
      .idx_o   (idx),
      .hit_o   (hit),
      .rd_ok_o (rd_ok),
      .wr_ok_o (wr_ok)
   );

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_word
         if (i >= NUM_WORDS) begin : g_void
            assign words[i] = '0;
         end else if (kind_of(i) == KIND_EXT) begin : g_ext
            assign words[i] = (i == IDX_SECONDS) ? sec_cnt_i : tick_cnt_i;
         end else begin : g_store
            logic hit_wr;
            assign hit_wr = wr_i && wr_ok && (idx == IDX_W'(i));
            clkctl_word_reg #(
               .KIND      (kind_of(i)),
               .RESET_VAL (cold_value(i))
            ) word_i (
               .clk_i   (clk_i),
               .rst_ni  (rst_ni),
               .wr_i    (hit_wr),
               .wdata_i (wdata_i),
               .q_o     (words[i])
            );
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_o <= '0;
         err_o   <= 1'b0;
      end else begin
         rdata_o <= (rd_i && rd_ok) ? words[idx] : '0;
         err_o   <= (rd_i && !rd_ok) || (wr_i && !wr_ok);
      end
   end

   // R8, R9
   bad_addr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !hit) |=> (rdata_o == '0 && err_o));
   // R6
   trig_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && hit && idx == IDX_W'(IDX_SWTRIG)) |=> (rdata_o == '0 && err_o));
   // R11
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_i && !wr_i) |=> (!err_o && rdata_o == '0));
   // R7
   ext_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && hit && (idx == IDX_W'(IDX_SECONDS) || idx == IDX_W'(IDX_TICKS))) |=> err_o);
endmodule

// File: tb/clkctl_regbank_tb.sv
module clkctl_regbank_tb_top;
   localparam int ADDR_W = 12;
   localparam int NW     = 28;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd = 1'b0, wr = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0]       wdata = '0, sec_cnt = '0, tick_cnt = '0;
   logic [31:0]       rdata;
   logic              err;

   int checks = 0;
   int errors = 0;
   logic [31:0] model [NW];

   always #2 clk = ~clk;

   clkctl_regbank #(.ADDR_W(ADDR_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
      .wdata_i(wdata), .sec_cnt_i(sec_cnt), .tick_cnt_i(tick_cnt),
      .rdata_o(rdata), .err_o(err)
   );

   function automatic logic [31:0] cold(int i);
      case (i)
         0, 10, 12, 14, 15, 16: return 32'hFFFF_FFFF;
         1:  return 32'h004A_AAAA;
         2:  return 32'h5413_F855;
         3:  return 32'h8022_2101;
         4:  return 32'h8020_2101;
         8:  return 32'h0000_1000;
         9:  return 32'h8000_0000;
         11: return 32'hAA4F_8F9F;
         13: return 32'h0300_0000;
         17: return 32'h0000_0003;
         21: return 32'h80C0_2105;
         23: return 32'h0400_0003;
         24: return 32'h8122_8606;
         25: return 32'h0000_00C8;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit is_pll(int i);
      return (i == 3 || i == 4 || i == 21 || i == 24);
   endfunction

   function automatic logic [31:0] pll_next(logic [31:0] old, logic [31:0] w);
      logic [31:0] v;
      v = w;
      if (w[12]) begin
         v[31] = 1'b0; v[30] = 1'b1;
      end else begin
         v[31] = 1'b1; v[30] = w[30] ? 1'b0 : old[30];
      end
      return v;
   endfunction

   function automatic string tag_of(logic [ADDR_W-1:0] a, logic r, logic w);
      int i;
      i = int'(a[ADDR_W-1:2]);
      if (a[1:0] != 2'b00) return "R9";
      if (i >= NW) return "R8";
      if (i == 5) return "R6";
      if (i == 26 || i == 27) return "R7";
      if (r && w) return "R10";
      if (is_pll(i)) return "R4";
      return "R2";
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // one access: drive at negedge, sample outputs at the following negedge
   task automatic access(logic r, logic w, logic [ADDR_W-1:0] a, logic [31:0] d, string req);
      int i;
      bit legal;
      logic [31:0] exp_rd;
      logic        exp_err;
      i = int'(a[ADDR_W-1:2]);
      legal = (a[1:0] == 2'b00) && (i < NW);
      exp_rd = 32'h0;
      exp_err = 1'b0;
      if (r) begin
         if (!legal || i == 5) exp_err = 1'b1;
         else if (i == 26) exp_rd = sec_cnt;
         else if (i == 27) exp_rd = tick_cnt;
         else exp_rd = model[i];
      end
      if (w) begin
         if (!legal || i == 26 || i == 27) exp_err = 1'b1;
         else if (i == 5) model[i] = 32'h0;
         else if (is_pll(i)) model[i] = pll_next(model[i], d);
         else model[i] = d;
      end
      @(negedge clk);
      rd = r; wr = w; addr = a; wdata = d;
      @(negedge clk);
      rd = 1'b0; wr = 1'b0;
      chk(req, rdata, exp_rd);
      chk(req, {31'h0, err}, {31'h0, exp_err});
   endtask

   task automatic rd_word(int i, string req);
      access(1'b1, 1'b0, ADDR_W'(i * 4), 32'h0, req);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int unused_seed;
      unused_seed = $urandom(32'h1234_5678);
      for (int i = 0; i < NW; i++) model[i] = cold(i);
      sec_cnt  = 32'h0000_0042;
      tick_cnt = 32'h017D_7840;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state outputs
      chk("R11", rdata, 32'h0);
      chk("R11", {31'h0, err}, 32'h0);

      // R1 cold values of every word except the trigger word
      for (int i = 0; i < NW; i++)
         if (i != 5) rd_word(i, "R1");

      // R2 plain full-word write
      access(1'b0, 1'b1, 12'h008, 32'hDEAD_BEEF, "R2");
      rd_word(2, "R2");
      // R3 power-down write
      access(1'b0, 1'b1, 12'h00C, 32'h0000_1234, "R3");
      rd_word(3, "R3");
      // R5 normal write with bit30 clear keeps loss flag
      access(1'b0, 1'b1, 12'h00C, 32'h0000_0101, "R5");
      rd_word(3, "R5");
      // R4 writing bit30 clears it
      access(1'b0, 1'b1, 12'h00C, 32'h4000_0101, "R4");
      rd_word(3, "R4");
      // R6 trigger word
      access(1'b0, 1'b1, 12'h014, 32'hFFFF_FFFF, "R6");
      rd_word(5, "R6");
      // R7 counters are read-only
      access(1'b0, 1'b1, 12'h068, 32'h1111_1111, "R7");
      rd_word(26, "R7");
      rd_word(27, "R7");
      // R8 out of range
      access(1'b1, 1'b0, 12'h070, 32'h0, "R8");
      access(1'b0, 1'b1, 12'hFFC, 32'h5555_5555, "R8");
      // R9 misaligned write must not reach word 0
      access(1'b0, 1'b1, 12'h002, 32'h0, "R9");
      rd_word(0, "R9");
      // R10 read and write together on a PLL word and a plain word
      access(1'b1, 1'b1, 12'h054, 32'h0000_1000, "R10");
      rd_word(21, "R10");
      access(1'b1, 1'b1, 12'h064, 32'h0000_0064, "R10");
      rd_word(25, "R10");
      // R11 idle cycle after an error
      access(1'b1, 1'b0, 12'h071, 32'h0, "R9");
      access(1'b0, 1'b0, 12'h000, 32'h0, "R11");

      // random traffic
      for (int n = 0; n < 400; n++) begin
         int sel;
         logic [ADDR_W-1:0] a;
         logic r, w;
         sel = int'($urandom % 10);
         if (sel < 6) a = ADDR_W'(($urandom % NW) * 4);
         else if (sel == 6) a = ADDR_W'(($urandom % (NW * 4)) | 1);
         else if (sel == 7) a = ADDR_W'(NW * 4 + ($urandom % 900) * 4);
         else a = (sel == 8) ? 12'h010 : 12'h060;
         r = 1'($urandom);
         w = 1'($urandom);
         if (n % 50 == 0) begin
            sec_cnt  = $urandom;
            tick_cnt = $urandom;
         end
         access(r, w, a, $urandom, tag_of(a, r, w));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule